// File: doc/BRIEF.md
# Watchdog Timer with Keyed Start/Stop

This block is a watchdog timer on a simple 32-bit register bus. Its 32-bit up-counter advances on a slow timer tick, nominally 32768 Hz, which is supplied as a one-cycle enable `tick` in the bus clock domain. The tick can optionally be divided by a power of two. When the counter rolls over past all-ones, the block emits a one-cycle reset pulse and reloads the counter from the load register. To time out after N prescaled ticks, software loads the bitwise complement of N-1.

Software can only arm or disarm the watchdog by writing a fixed pair of key words, in order, to the start/stop register. To service the watchdog, software writes a new value to the trigger register, which copies the load value into the counter. Every register write is posted. A per-register pending flag stays set until the second tick after the write, and the new value takes effect on that tick.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog is disarmed, and the control, counter, load, trigger and pending registers read 0. The identity register at 0x00 reads the `REV_ID` parameter (default 0x31) in bits 7:0 and 0 above them.
- R2: The watchdog arms only after 0x0000BBBB is committed to offset 0x48 and 0x00004444 is committed immediately after it. Once armed, the counter advances on prescaled ticks.
- R3: The watchdog disarms only after 0x0000AAAA is committed to offset 0x48 and 0x00005555 is committed immediately after it. Once disarmed, the counter holds its value across ticks.
- R4: Any other word committed to 0x48 breaks a half-entered key sequence, and a second key word on its own has no effect. Offset 0x48 reads back the last committed word.
- R5: In the control register at 0x24, bit 5 enables the prescaler and bits 4:2 hold PTV, and reads return those fields in the same bits. With bit 5 set, the counter advances once every 2^PTV ticks. With bit 5 clear, it advances on every tick.
- R6: The counter overflows on the tick that takes it past all-ones. That tick is the N-th step after the counter holds the complement of N-1. On the clock cycle after that tick, `wd_rst` is high for exactly one cycle, and the counter reloads from the load register at 0x2C.
- R7: A committed write to the trigger register at 0x30 copies the load value into the counter only when its value differs from the previous trigger value. Writing the same value leaves the counter unchanged.
- R8: Offset 0x34 holds one pending flag per register: bit 0 control, bit 1 counter, bit 2 load, bit 3 trigger, bit 4 start/stop. A flag reads 1 from the cycle after its register is written. The flag clears, and the register takes its new value, at the second tick after the write.
- R9: Read data appears on `bus_rdata` one cycle after the read request. A committed write to 0x28 sets the counter, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timer tick enable |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| wd_rst | output | 1 | One-cycle reset pulse on overflow |

## Verification
The results of this block fall due at three points. A pending flag reads 1 on the cycle after its write. A posted value, and the clearing of its flag, appear on the second tick edge after the write. The reset pulse appears on the clock cycle right after the tick edge on which the counter overflows. The bench drives every input at the falling clock edge, so each request or tick is consumed at the following rising edge. It samples the outputs at the next falling edge, which is the first point at which a registered result is visible. In the prescaler sweep, the bench counts ticks from the arming commit up to the pulse and compares the count with N·2^PTV, or with N when the prescaler is off. It then counts a second full period to check the reload.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int NSLOT   = 5;
    localparam int SL_CTRL = 0;
    localparam int SL_CNT  = 1;
    localparam int SL_LOAD = 2;
    localparam int SL_TRIG = 3;
    localparam int SL_KEY  = 4;

    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h24;
    localparam logic [7:0] OFS_CNT  = 8'h28;
    localparam logic [7:0] OFS_LOAD = 8'h2C;
    localparam logic [7:0] OFS_TRIG = 8'h30;
    localparam logic [7:0] OFS_PEND = 8'h34;
    localparam logic [7:0] OFS_KEY  = 8'h48;

    localparam logic [31:0] KEY_ARM_1    = 32'h0000_BBBB;
    localparam logic [31:0] KEY_ARM_2    = 32'h0000_4444;
    localparam logic [31:0] KEY_DISARM_1 = 32'h0000_AAAA;
    localparam logic [31:0] KEY_DISARM_2 = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_ARM    = 2'd1,
        KS_DISARM = 2'd2
    } key_st_e;

    typedef struct packed {
        key_st_e st;
        logic    en;
    } key_state_t;

    function automatic logic [7:0] slot_ofs(input int idx);
        case (idx)
            SL_CTRL: slot_ofs = OFS_CTRL;
            SL_CNT:  slot_ofs = OFS_CNT;
            SL_LOAD: slot_ofs = OFS_LOAD;
            SL_TRIG: slot_ofs = OFS_TRIG;
            default: slot_ofs = OFS_KEY;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int DW   = 32,
    parameter int HOLD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          pend,
    output logic          commit,
    output logic [DW-1:0] data
);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic          pend;
        logic [HW-1:0] left;
        logic [DW-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (wr) begin
            st_d.pend = 1'b1;
            st_d.left = HW'(HOLD);
            st_d.data = wdata;
        end else if (st_q.pend && tick) begin
            if (st_q.left == HW'(1)) begin
                st_d.pend = 1'b0;
                st_d.left = '0;
                commit    = 1'b1;
            end else begin
                st_d.left = st_q.left - HW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign data = st_q.data;
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             step
);
    localparam int CW = (1 << PTV_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   lim;

    always_comb begin
        lim   = ((CW + 1)'(1) << ptv) - (CW + 1)'(1);
        step  = tick && run && (!pre_en || (cnt_q == lim[CW-1:0]));
        cnt_d = cnt_q;
        if (!run || clr)     cnt_d = '0;
        else if (step)       cnt_d = '0;
        else if (tick)       cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [DW-1:0] word,
    output logic          en
);
    key_state_t ks_d, ks_q;

    always_comb begin
        ks_d = ks_q;
        if (commit) begin
            if (word == DW'(KEY_ARM_1)) begin
                ks_d.st = KS_ARM;
            end else if (word == DW'(KEY_DISARM_1)) begin
                ks_d.st = KS_DISARM;
            end else if (ks_q.st == KS_ARM && word == DW'(KEY_ARM_2)) begin
                ks_d.st = KS_IDLE;
                ks_d.en = 1'b1;
            end else if (ks_q.st == KS_DISARM && word == DW'(KEY_DISARM_2)) begin
                ks_d.st = KS_IDLE;
                ks_d.en = 1'b0;
            end else begin
                ks_d.st = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ks_q <= '{st: KS_IDLE, en: 1'b0};
        else        ks_q <= ks_d;
    end

    assign en = ks_q.en;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdt_pkg::*;
#(
    parameter int         CNT_W  = 32,
    parameter int         AW     = 8,
    parameter int         DW     = 32,
    parameter int         PTV_W  = 3,
    parameter int         HOLD   = 2,
    parameter logic [7:0] REV_ID = 8'h31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wd_rst
);
    localparam int PTV_LSB = 2;
    localparam int PRE_BIT = PTV_LSB + PTV_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        logic [DW-1:0]    trig;
        logic [DW-1:0]    key_last;
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
        logic             pulse;
        logic [DW-1:0]    rdata;
    } core_t;

    core_t st_d, st_q;

    logic [NSLOT-1:0] wr_sel;
    logic [NSLOT-1:0] pend;
    logic [NSLOT-1:0] commit;
    logic [PTV_W:0]   ctrl_data;
    logic [CNT_W-1:0] cnt_data;
    logic [CNT_W-1:0] load_data;
    logic [DW-1:0]    trig_data;
    logic [DW-1:0]    key_data;
    logic             key_en;
    logic             step;
    logic [DW-1:0]    rd_mux;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [AW-1:0] SOFS = AW'(slot_ofs(g));
        assign wr_sel[g] = bus_valid && bus_write && (bus_addr == SOFS);
        if (g == SL_CTRL) begin : g_ctrl
            wdt_post_slot #(.DW(PTV_W + 1), .HOLD(HOLD)) u_slot (
                .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_sel[g]),
                .wdata(bus_wdata[PRE_BIT:PTV_LSB]),
                .pend(pend[g]), .commit(commit[g]), .data(ctrl_data));
        end else if (g == SL_CNT) begin : g_cnt
            wdt_post_slot #(.DW(CNT_W), .HOLD(HOLD)) u_slot (
                .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_sel[g]),
                .wdata(bus_wdata[CNT_W-1:0]),
                .pend(pend[g]), .commit(commit[g]), .data(cnt_data));
        end else if (g == SL_LOAD) begin : g_load
            wdt_post_slot #(.DW(CNT_W), .HOLD(HOLD)) u_slot (
                .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_sel[g]),
                .wdata(bus_wdata[CNT_W-1:0]),
                .pend(pend[g]), .commit(commit[g]), .data(load_data));
        end else if (g == SL_TRIG) begin : g_trig
            wdt_post_slot #(.DW(DW), .HOLD(HOLD)) u_slot (
                .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_sel[g]),
                .wdata(bus_wdata),
                .pend(pend[g]), .commit(commit[g]), .data(trig_data));
        end else begin : g_key
            wdt_post_slot #(.DW(DW), .HOLD(HOLD)) u_slot (
                .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_sel[g]),
                .wdata(bus_wdata),
                .pend(pend[g]), .commit(commit[g]), .data(key_data));
        end
    end

    wdt_keyseq #(.DW(DW)) u_keys (
        .clk(clk), .rst_n(rst_n), .commit(commit[SL_KEY]),
        .word(key_data), .en(key_en));

    wdt_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(key_en),
        .clr(commit[SL_CTRL]), .pre_en(st_q.pre_en), .ptv(st_q.ptv),
        .step(step));

    always_comb begin
        rd_mux = '0;
        if (bus_addr == AW'(OFS_ID))        rd_mux = DW'(REV_ID);
        else if (bus_addr == AW'(OFS_CTRL)) rd_mux = DW'({st_q.pre_en, st_q.ptv}) << PTV_LSB;
        else if (bus_addr == AW'(OFS_CNT))  rd_mux = DW'(st_q.cnt);
        else if (bus_addr == AW'(OFS_LOAD)) rd_mux = DW'(st_q.load);
        else if (bus_addr == AW'(OFS_TRIG)) rd_mux = st_q.trig;
        else if (bus_addr == AW'(OFS_PEND)) rd_mux = DW'(pend);
        else if (bus_addr == AW'(OFS_KEY))  rd_mux = st_q.key_last;
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (commit[SL_CTRL]) begin
            st_d.pre_en = ctrl_data[PTV_W];
            st_d.ptv    = ctrl_data[PTV_W-1:0];
        end
        if (commit[SL_LOAD]) st_d.load     = load_data;
        if (commit[SL_KEY])  st_d.key_last = key_data;
        if (commit[SL_TRIG]) st_d.trig     = trig_data;
        if (commit[SL_CNT]) begin
            st_d.cnt = cnt_data;
        end else if (commit[SL_TRIG] && (trig_data != st_q.trig)) begin
            st_d.cnt = st_q.load;
        end else if (step) begin
            if (&st_q.cnt) begin
                st_d.cnt   = st_q.load;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (bus_valid && !bus_write) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign wd_rst    = st_q.pulse;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
    import wdt_pkg::*;
#(
    parameter int AW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [AW-1:0]    bus_addr,
    input logic             wd_rst,
    input logic             en,
    input logic [NSLOT-1:0] pend
);
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> !wd_rst);

    // R6
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> ($past(tick) && $past(en)));

    // R2
    arm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(tick));

    // R3
    disarm_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(tick));

    for (genvar g = 0; g < NSLOT; g++) begin : g_pend
        localparam logic [AW-1:0] SOFS = AW'(slot_ofs(g));
        // R8
        pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && bus_addr == SOFS) |=> pend[g]);
        // R8
        pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[g]) |-> $past(tick));
    end
endmodule

bind wdog_keyed wdog_keyed_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .wd_rst(wd_rst),
    .en(key_en), .pend(pend));

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst;

    int checks = 0;
    int errors = 0;
    logic after_pulse = 1'b0;
    logic [31:0] trig_val = 32'h0;

    always #5ns clk = ~clk;

    wdog_keyed uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wd_rst(wd_rst));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_tick(output logic p);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        p = wd_rst;
        @(negedge clk);
        after_pulse = wd_rst;
    endtask

    task automatic ticks(input int n);
        logic p;
        for (int i = 0; i < n; i++) do_tick(p);
    endtask

    task automatic wr_post(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        ticks(2);
    endtask

    task automatic count_to_pulse(output int k);
        logic p;
        k = 0;
        p = 1'b0;
        while (!p && k < 400) begin
            do_tick(p);
            k++;
        end
    endtask

    task automatic run_cfg(input int pre, input int ptv, input int n);
        int div, k;
        logic [31:0] c1, c2;
        string tag;
        div = (pre != 0) ? (1 << ptv) : 1;
        tag = $sformatf("pre=%0d ptv=%0d n=%0d", pre, ptv, n);
        wr_post(8'h24, 32'((pre << 5) | (ptv << 2)));
        wr_post(8'h2C, ~32'(n - 1));
        trig_val = trig_val + 32'd1;
        wr_post(8'h30, trig_val);
        wr_post(8'h48, 32'h0000_BBBB);
        wr_post(8'h48, 32'h0000_4444);
        count_to_pulse(k);
        // R5 R6 R2: first timeout after n*2^ptv ticks
        chk({"R5 first period ", tag}, 32'(k), 32'(n * div));
        // R6: pulse lasts one cycle
        chk({"R6 pulse width ", tag}, {31'd0, after_pulse}, 32'd0);
        count_to_pulse(k);
        // R6: reload from load register gives same period
        chk({"R6 reload period ", tag}, 32'(k), 32'(n * div));
        wr_post(8'h48, 32'h0000_AAAA);
        wr_post(8'h48, 32'h0000_5555);
        rd(8'h28, c1);
        ticks(3);
        rd(8'h28, c2);
        // R3: disarmed counter frozen
        chk({"R3 frozen ", tag}, c2, c1);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 wd_rst", {31'd0, wd_rst}, 32'd0);
        rd(8'h00, v); chk("R1 id", v, 32'h0000_0031);
        rd(8'h24, v); chk("R1 ctrl", v, 32'd0);
        rd(8'h28, v); chk("R1 counter", v, 32'd0);
        rd(8'h2C, v); chk("R1 load", v, 32'd0);
        rd(8'h34, v); chk("R1 pending", v, 32'd0);
        ticks(3);
        rd(8'h28, v); chk("R1 disarmed counter", v, 32'd0);

        // R8 posted write to load
        wr(8'h2C, 32'h55);
        rd(8'h34, v); chk("R8 pend set", v, 32'h4);
        rd(8'h2C, v); chk("R8 load old", v, 32'h0);
        ticks(1);
        rd(8'h34, v); chk("R8 pend after 1 tick", v, 32'h4);
        ticks(1);
        rd(8'h34, v); chk("R8 pend cleared", v, 32'h0);
        rd(8'h2C, v); chk("R8 load new", v, 32'h55);
        wr(8'h30, 32'h0);
        rd(8'h34, v); chk("R8 trig pend bit3", v, 32'h8);
        ticks(2);

        // R9 counter write and unmapped read
        wr_post(8'h28, 32'h1234);
        rd(8'h28, v); chk("R9 counter write", v, 32'h1234);
        rd(8'h04, v); chk("R9 unmapped", v, 32'h0);

        // R5 ctrl readback
        wr_post(8'h24, 32'h0000_002C);
        rd(8'h24, v); chk("R5 ctrl readback", v, 32'h2C);
        wr_post(8'h24, 32'h0);

        // R7 trigger
        wr_post(8'h30, trig_val);
        rd(8'h28, v); chk("R7 same trigger no reload", v, 32'h1234);
        trig_val = trig_val + 32'd1;
        wr_post(8'h30, trig_val);
        rd(8'h28, v); chk("R7 new trigger reload", v, 32'h55);

        // R4 broken sequences
        wr_post(8'h48, 32'h0000_4444);
        ticks(3);
        rd(8'h28, v); chk("R4 lone second word", v, 32'h55);
        wr_post(8'h48, 32'h0000_BBBB);
        wr_post(8'h48, 32'h0000_1234);
        wr_post(8'h48, 32'h0000_4444);
        ticks(3);
        rd(8'h28, v); chk("R4 interrupted sequence", v, 32'h55);
        wr_post(8'h48, 32'h0000_AAAA);
        wr_post(8'h48, 32'h0000_4444);
        ticks(3);
        rd(8'h28, v); chk("R4 mixed keys", v, 32'h55);
        rd(8'h48, v); chk("R4 key readback", v, 32'h0000_4444);

        // R2 repeated first word then second arms
        wr_post(8'h48, 32'h0000_BBBB);
        wr_post(8'h48, 32'h0000_BBBB);
        wr_post(8'h48, 32'h0000_4444);
        ticks(3);
        rd(8'h28, v); chk("R2 armed counts", v, 32'h58);
        wr_post(8'h48, 32'h0000_AAAA);
        wr_post(8'h48, 32'h0000_5555);

        // R5 R6 sweep
        for (int pre = 0; pre < 2; pre++)
            for (int ptv = 0; ptv < 3; ptv++)
                for (int n = 1; n <= 3; n++)
                    run_cfg(pre, ptv, n);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500us;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule